// File: doc/BRIEF.md
# Column-Indexed Cache-Line Shuffle Network

This block rearranges the eight chip-sized words of one 512-bit cache line before the line travels to a memory rank built from eight chips. Every cache line normally places word j on chip j, so words that sit at the same offset in successive lines all land on one chip. Here the placement instead depends on the low three bits of the line's DRAM column address. Each line in a row therefore takes its own arrangement. With that arrangement, the words of a power-of-two strided pattern fall on different chips, and one column command can fetch all of them.

The network is built from three swap stages, and each low column bit turns on one stage. Stage 1 swaps neighbouring slots, stage 2 swaps neighbouring pairs and stage 3 swaps the two halves. Together the three stages move slot i to slot i XOR col[2:0]. The mapping is its own inverse, so read data passes through the same network with the same column bits to get back its original order. A direction flag travels beside the data so that later logic knows whether the beat is outbound or returning. A parameter picks either a purely combinational path or a single output register qualified by a valid bit.

Top module: `cls_shuffle_top`

## Requirements
- R1: Output slot i (bits 64i+63..64i of the line) carries input slot i XOR col[2:0], for every i in 0..7.
- R2: Column bit 0 alone swaps adjacent slots, bit 1 alone swaps adjacent slot pairs, and bit 2 alone swaps the lower four slots with the upper four.
- R3: Column address bits above bit 2 have no effect on the output line.
- R4: When col[2:0] is 0 the output line equals the input line.
- R5: Passing a shuffled line back through the block with the same column bits returns the original line.
- R6: The direction flag does not change the permutation, and out_dir repeats in_dir for the same beat.
- R7: With LATENCY=1, out_valid and the permuted line appear exactly one clock after in_valid is sampled high, and out_valid is low one clock after in_valid is sampled low. With LATENCY=0 they follow the inputs in the same cycle.
- R8: A synchronous active-high reset forces out_valid low on the next clock, even if in_valid is high at the same time.
- R9: With LATENCY=1, out_line and out_dir hold their last values while in_valid is low.
- R10: Word 0 of the eight lines at column addresses 0..7 lands on eight distinct chip slots, namely slot c for column c.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat is valid |
| in_dir | input | 1 | Beat direction: 0 toward the chips, 1 returning from them |
| in_col | input | COL_W | DRAM column address of the line |
| in_line | input | 512 | Cache line, slot j at bits 64j+63..64j |
| out_valid | output | 1 | Output beat is valid |
| out_dir | output | 1 | Direction of the output beat |
| out_line | output | 512 | Permuted cache line |

## Verification
The assertions check the timing on every cycle: valid follows valid with the set latency, reset clears valid, and the register holds its value while idle. They also check that the direction flag tracks its beat, that output slot 0 carries the input slot named by the column bits, and that a zero column passes the line unchanged. Some properties need whole lines and chosen patterns, and only the bench scenarios show them. These are the full eight-slot permutation for every column value, the per-stage swaps, the blindness to upper column bits, the read-side round trip, and the spreading of strided words over distinct chips.

// File: rtl/cls_pkg.sv
package cls_pkg;

    localparam int unsigned SLOTS  = 8;
    localparam int unsigned WORD_W = 64;
    localparam int unsigned SEL_W  = $clog2(SLOTS);
    localparam int unsigned LINE_W = SLOTS * WORD_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef word_t [SLOTS-1:0] line_t;

    typedef enum logic {
        DIR_TO_CHIPS   = 1'b0,
        DIR_FROM_CHIPS = 1'b1
    } dir_e;

    typedef struct packed {
        dir_e  dir;
        line_t line;
    } beat_t;

    // Partner slot of index idx inside a stage whose groups are 2**stage wide.
    function automatic int unsigned stage_partner(int unsigned idx, int unsigned stage);
        return idx ^ (32'd1 << stage);
    endfunction

endpackage

// File: rtl/cls_swap_stage.sv
module cls_swap_stage
    import cls_pkg::*;
#(
    parameter int unsigned STAGE = 0
) (
    input  logic  en,
    input  line_t din,
    output line_t dout
);

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        localparam int unsigned PARTNER = stage_partner(i, STAGE);
        assign dout[i] = en ? din[PARTNER] : din[i];
    end

endmodule

// File: rtl/cls_swap_net.sv
module cls_swap_net
    import cls_pkg::*;
#(
    parameter int unsigned COL_W = 10
) (
    input  logic [COL_W-1:0] col,
    input  line_t            din,
    output line_t            dout
);

    line_t stage_d [SEL_W+1];

    assign stage_d[0] = din;

    for (genvar s = 0; s < SEL_W; s++) begin : g_stage
        cls_swap_stage #(
            .STAGE (s)
        ) u_stage (
            .en   (col[s]),
            .din  (stage_d[s]),
            .dout (stage_d[s+1])
        );
    end

    assign dout = stage_d[SEL_W];

endmodule

// File: rtl/cls_out_stage.sv
module cls_out_stage
    import cls_pkg::*;
#(
    parameter int unsigned LATENCY = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_vld,
    input  beat_t in_beat,
    output logic  out_vld,
    output beat_t out_beat
);

    if (LATENCY == 0) begin : g_comb
        assign out_vld  = in_vld;
        assign out_beat = in_beat;
    end else begin : g_reg
        logic  vld_q;
        beat_t beat_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= 1'b0;
            end else begin
                vld_q <= in_vld;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                beat_q <= '0;
            end else if (in_vld) begin
                beat_q <= in_beat;
            end
        end

        assign out_vld  = vld_q;
        assign out_beat = beat_q;
    end

endmodule

// File: rtl/cls_shuffle_top.sv
module cls_shuffle_top
    import cls_pkg::*;
#(
    parameter int unsigned COL_W   = 10,
    parameter int unsigned LATENCY = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_dir,
    input  logic [COL_W-1:0]  in_col,
    input  logic [LINE_W-1:0] in_line,
    output logic              out_valid,
    output logic              out_dir,
    output logic [LINE_W-1:0] out_line
);

    line_t net_out;
    beat_t beat_d;
    beat_t beat_q;

    cls_swap_net #(
        .COL_W (COL_W)
    ) u_net (
        .col  (in_col),
        .din  (line_t'(in_line)),
        .dout (net_out)
    );

    assign beat_d.dir  = dir_e'(in_dir);
    assign beat_d.line = net_out;

    cls_out_stage #(
        .LATENCY (LATENCY)
    ) u_out (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (in_valid),
        .in_beat  (beat_d),
        .out_vld  (out_valid),
        .out_beat (beat_q)
    );

    assign out_dir  = beat_q.dir;
    assign out_line = beat_q.line;

endmodule

// File: rtl/cls_shuffle_chk.sv
module cls_shuffle_chk
    import cls_pkg::*;
#(
    parameter int unsigned COL_W   = 10,
    parameter int unsigned LATENCY = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_dir,
    input logic [COL_W-1:0]  in_col,
    input logic [LINE_W-1:0] in_line,
    input logic              out_valid,
    input logic              out_dir,
    input logic [LINE_W-1:0] out_line
);

    line_t in_slots;
    line_t out_slots;
    word_t src_word0;
    logic  col_zero;

    assign in_slots  = in_line;
    assign out_slots = out_line;
    assign src_word0 = in_slots[in_col[SEL_W-1:0]];
    assign col_zero  = (in_col[SEL_W-1:0] == '0);

    if (LATENCY != 0) begin : g_seq
        // R7: valid rises one clock after an accepted beat
        a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);
        // R7: valid drops one clock after an idle input cycle
        a_r7_idle_follows: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);
        // R8: reset clears valid regardless of in_valid
        a_r8_reset_clears: assert property (@(posedge clk)
            rst |=> !out_valid);
        // R9: the output register holds while idle
        a_r9_hold_line: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> $stable(out_line) && $stable(out_dir));
        // R6: the direction flag travels with its beat
        a_r6_dir_tracks: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_dir == $past(in_dir));
        // R1: slot 0 of the output is input slot col[2:0]
        a_r1_slot0_source: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_slots[0] == $past(src_word0));
        // R4: zero column leaves the line untouched
        a_r4_zero_identity: assert property (@(posedge clk) disable iff (rst)
            in_valid && col_zero |=> out_line == $past(in_line));
    end else begin : g_comb
        // R7: zero latency passes valid through
        a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
            out_valid == in_valid);
        // R6: the direction flag travels with its beat
        a_r6_dir_tracks: assert property (@(posedge clk) disable iff (rst)
            in_valid |-> out_dir == in_dir);
        // R1: slot 0 of the output is input slot col[2:0]
        a_r1_slot0_source: assert property (@(posedge clk) disable iff (rst)
            in_valid |-> out_slots[0] == src_word0);
        // R4: zero column leaves the line untouched
        a_r4_zero_identity: assert property (@(posedge clk) disable iff (rst)
            in_valid && col_zero |-> out_line == in_line);
    end

endmodule

bind cls_shuffle_top cls_shuffle_chk #(
    .COL_W   (COL_W),
    .LATENCY (LATENCY)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_dir    (in_dir),
    .in_col    (in_col),
    .in_line   (in_line),
    .out_valid (out_valid),
    .out_dir   (out_dir),
    .out_line  (out_line)
);

// File: tb/tb_cls_shuffle_top.sv
module tb_cls_shuffle_top;
    import cls_pkg::*;

    localparam int unsigned COL_W = 10;

    typedef struct {
        line_t line;
        logic  dir;
        string tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_dir = 1'b0;
    logic [COL_W-1:0]  in_col = '0;
    logic [LINE_W-1:0] in_line = '0;
    logic              out_valid;
    logic              out_dir;
    logic [LINE_W-1:0] out_line;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    exp_t  q[$];
    line_t last_out;
    line_t captured;

    always #2 clk = ~clk;

    cls_shuffle_top #(
        .COL_W   (COL_W),
        .LATENCY (1)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_dir    (in_dir),
        .in_col    (in_col),
        .in_line   (in_line),
        .out_valid (out_valid),
        .out_dir   (out_dir),
        .out_line  (out_line)
    );

    // Expected placement from R1: output slot i takes input slot i ^ col[2:0].
    function automatic line_t expect_perm(line_t src, logic [COL_W-1:0] col);
        line_t r;
        for (int i = 0; i < SLOTS; i++) r[i] = src[i ^ int'(col[SEL_W-1:0])];
        return r;
    endfunction

    function automatic line_t make_line(int seed);
        line_t r;
        for (int i = 0; i < SLOTS; i++)
            r[i] = {16'hC0DE, 16'(seed), 24'h0, 8'(i)} ^ {$urandom(), 32'h0};
        return r;
    endfunction

    task automatic check(bit ok, string tag, logic [LINE_W-1:0] act, logic [LINE_W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Driver: called at a falling edge, presents one beat for one cycle.
    task automatic drive(logic [COL_W-1:0] col, line_t ln, logic dir, line_t exp, string tag);
        exp_t e;
        in_valid = 1'b1;
        in_col   = col;
        in_line  = ln;
        in_dir   = dir;
        e.line = exp;
        e.dir  = dir;
        e.tag  = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: samples shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && out_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R7 unexpected out_valid", out_line, '0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(out_line == e.line, e.tag, out_line, e.line);
                    check(out_dir == e.dir, {e.tag, " R6 dir"}, LINE_W'(out_dir), LINE_W'(e.dir));
                    last_out = out_line;
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        line_t a, b, sh, mk;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R8 reset state valid", LINE_W'(out_valid), '0);
        check(out_line == '0, "R8 reset state line", out_line, '0);
        @(negedge clk);

        // R4: zero column is identity
        a = make_line(1);
        drive(10'd0, a, 1'b0, a, "R4 identity");
        // R2: single-stage patterns on a line of slot indices
        for (int i = 0; i < SLOTS; i++) b[i] = word_t'(i);
        drive(10'd1, b, 1'b0, {64'd6,64'd7,64'd4,64'd5,64'd2,64'd3,64'd0,64'd1}, "R2 stage1 pairs");
        drive(10'd2, b, 1'b0, {64'd5,64'd4,64'd7,64'd6,64'd1,64'd0,64'd3,64'd2}, "R2 stage2 pairs of pairs");
        drive(10'd4, b, 1'b0, {64'd3,64'd2,64'd1,64'd0,64'd7,64'd6,64'd5,64'd4}, "R2 stage3 halves");
        // R1: every column value on random lines
        for (int c = 0; c < SLOTS; c++) begin
            a = make_line(10 + c);
            drive(COL_W'(c), a, c[0], expect_perm(a, COL_W'(c)), "R1 permutation");
        end
        idle(2);
        // R9: register holds while idle
        check(out_valid == 1'b0, "R7 valid low when idle", LINE_W'(out_valid), '0);
        check(out_line == last_out, "R9 hold while idle", out_line, last_out);

        // R3: upper column bits ignored
        a = make_line(30);
        drive(10'h3F5, a, 1'b0, expect_perm(a, 10'd5), "R3 upper bits ignored");
        drive(10'h008, a, 1'b0, a, "R3 upper bits only");
        // R5/R6: write shuffle then read back with dir set
        a  = make_line(40);
        sh = expect_perm(a, 10'd6);
        drive(10'd6, a, 1'b0, sh, "R6 write direction");
        drive(10'd6, sh, 1'b1, a, "R5 read round trip");
        // R10: word 0 of lines at columns 0..7 spreads to chip c
        for (int c = 0; c < SLOTS; c++) begin
            mk = '0;
            mk[0] = 64'hFEED_0000_0000_0000 | 64'(c);
            captured = '0;
            captured[c] = mk[0];
            drive(COL_W'(c), mk, 1'b0, captured, "R10 strided spread");
        end
        idle(3);

        // R8: reset wins over a simultaneous valid beat
        a = make_line(50);
        drive(10'd3, a, 1'b0, expect_perm(a, 10'd3), "R7 single beat");
        rst = 1'b1;
        in_valid = 1'b1;
        in_line = make_line(51);
        @(negedge clk);
        check(out_valid == 1'b0, "R8 reset over valid", LINE_W'(out_valid), '0);
        rst = 1'b0;
        idle(2);

        check(q.size() == 0, "R7 all beats emitted", LINE_W'(q.size()), '0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule